// File: doc/BRIEF.md
# Configuration Change Unlock Guard

This block protects sensitive actions from stray software writes. Software must first write a magic value to an 8-bit key register. One value opens a short window in which the protected I/O registers may be written. A second value opens a window for protected self-programming or program-memory read instructions. The window closes automatically after a fixed number of retired instructions, four by default. It closes earlier once the protected action it guards has been performed.

While a window is open, the block tells the interrupt controller to hold off accepting interrupts. Once the window closes, pending interrupts are serviced in the normal way. Reading the key register shows which window is open: one status bit per mode, with every other bit reading as zero.

The block drives an unlock enable for each mode. If a protected register write arrives while the register window is closed, the write is blocked and the block raises a one-cycle violation flag.

Top module: `chg_guard`

## Requirements
- R1: After reset, `key_rdata` is 0x00 and `reg_unlock`, `prog_unlock`, `irq_mask` and `reg_violation` are all low.
- R2: A key write of 0xD8 opens the register window from the next cycle: `reg_unlock` is 1, `prog_unlock` is 0 and `key_rdata` is 0x01 (bit 0 set).
- R3: A key write of 0x9D opens the program window from the next cycle: `prog_unlock` is 1, `reg_unlock` is 0 and `key_rdata` is 0x02 (bit 1 set).
- R4: An open window stays open through three `instr_retire` pulses. It closes in the cycle after the fourth pulse counted since it was opened.
- R5: `irq_mask` is high in exactly those cycles in which a window is open.
- R6: Bits 7 to 2 of `key_rdata` always read as zero.
- R7: A key write of any value other than 0xD8 or 0x9D is ignored. It opens no window, and it changes neither the open mode nor its remaining count.
- R8: A valid key write while a window is open selects the new mode and restarts the count at four. The key write takes priority over an `instr_retire` pulse in the same cycle. At most one mode is open at a time.
- R9: A `prot_reg_wr` pulse under the register window, or a `prot_prog_exec` pulse under the program window, closes that window in the next cycle. A pulse of the other kind does not close it.
- R10: A `prot_reg_wr` pulse while the register window is closed sets `reg_violation` high for exactly the next cycle. A pulse under an open register window sets no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_we | input | 1 | Write strobe for the key register |
| key_wdata | input | 8 | Data for the key register write |
| instr_retire | input | 1 | One pulse per retired CPU instruction |
| prot_reg_wr | input | 1 | A protected I/O register write is attempted |
| prot_prog_exec | input | 1 | A protected program-memory instruction executes |
| key_rdata | output | 8 | Key register read-back: bit 0 is the register window, bit 1 is the program window |
| reg_unlock | output | 1 | Protected register writes are enabled |
| prog_unlock | output | 1 | Protected program-memory instructions are enabled |
| irq_mask | output | 1 | Interrupt acceptance is suppressed |
| reg_violation | output | 1 | One-cycle pulse: a protected register write was blocked |

## Verification
Several functions can land in the same clock cycle, and each pairing is set up on purpose. A fresh signature write can arrive together with the retire pulse that would have ended the old window. That pulse must lose to the restart. A protected register write can arrive under the program window: it must raise a violation while the program window stays open. A junk key write can arrive together with a retire pulse: the count must still advance. A reference model in the bench predicts the outputs for every such cycle. A scoreboard then compares the whole output vector one edge later.

// File: rtl/chg_guard_pkg.sv
package chg_guard_pkg;
  localparam int KEY_W = 8;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_REG  = 2'd1,
    WIN_PROG = 2'd2
  } win_t;

  // Map a written key value onto the window it selects.
  function automatic win_t key_to_win(input logic [KEY_W-1:0] d,
                                      input logic [KEY_W-1:0] sig_reg,
                                      input logic [KEY_W-1:0] sig_prog);
    win_t w;
    w = WIN_NONE;
    if (d == sig_reg)  w = WIN_REG;
    if (d == sig_prog) w = WIN_PROG;
    return w;
  endfunction

  // Read-back status bit for a given bit position.
  function automatic logic status_bit(input win_t m, input int pos);
    logic b;
    b = 1'b0;
    if (pos == 0) b = (m == WIN_REG);
    if (pos == 1) b = (m == WIN_PROG);
    return b;
  endfunction
endpackage

// File: rtl/chg_guard_decode.sv
module chg_guard_decode
  import chg_guard_pkg::*;
#(
  parameter logic [KEY_W-1:0] SIG_REG  = 8'hD8,
  parameter logic [KEY_W-1:0] SIG_PROG = 8'h9D
) (
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_wdata,
  output win_t             sel,
  output logic             hit
);
  win_t dec;

  always_comb begin
    dec = key_to_win(key_wdata, SIG_REG, SIG_PROG);
    sel = dec;
    hit = key_we && (dec != WIN_NONE);
  end
endmodule

// File: rtl/chg_guard_window.sv
module chg_guard_window
  import chg_guard_pkg::*;
#(
  parameter int WINDOW_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  win_t sel,
  input  logic instr_retire,
  input  logic prot_reg_wr,
  input  logic prot_prog_exec,
  output win_t mode,
  output logic early_close,
  output logic expire
);
  localparam int CNT_W = $clog2(WINDOW_LEN + 1);

  win_t             mode_q;
  logic [CNT_W-1:0] left_q;

  always_comb begin
    early_close = ((mode_q == WIN_REG)  && prot_reg_wr) ||
                  ((mode_q == WIN_PROG) && prot_prog_exec);
    expire      = (mode_q != WIN_NONE) && instr_retire && (left_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= WIN_NONE;
      left_q <= '0;
    end else if (hit) begin
      mode_q <= sel;
      left_q <= CNT_W'(WINDOW_LEN);
    end else if (early_close || expire) begin
      mode_q <= WIN_NONE;
      left_q <= '0;
    end else if ((mode_q != WIN_NONE) && instr_retire) begin
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/chg_guard_viol.sv
module chg_guard_viol
  import chg_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  win_t mode,
  input  logic prot_reg_wr,
  output logic blocked,
  output logic violation
);
  assign blocked = prot_reg_wr && (mode != WIN_REG);

  always_ff @(posedge clk) begin
    if (!rst_n) violation <= 1'b0;
    else        violation <= blocked;
  end
endmodule

// File: rtl/chg_guard.sv
module chg_guard
  import chg_guard_pkg::*;
#(
  parameter int                WINDOW_LEN = 4,
  parameter logic [KEY_W-1:0]  SIG_REG    = 8'hD8,
  parameter logic [KEY_W-1:0]  SIG_PROG   = 8'h9D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_wdata,
  input  logic             instr_retire,
  input  logic             prot_reg_wr,
  input  logic             prot_prog_exec,
  output logic [KEY_W-1:0] key_rdata,
  output logic             reg_unlock,
  output logic             prog_unlock,
  output logic             irq_mask,
  output logic             reg_violation
);
  win_t sel;
  win_t mode;
  logic key_hit;
  logic early_close;
  logic win_expire;
  logic reg_blocked;

  chg_guard_decode #(.SIG_REG(SIG_REG), .SIG_PROG(SIG_PROG)) i_decode (
    .key_we    (key_we),
    .key_wdata (key_wdata),
    .sel       (sel),
    .hit       (key_hit)
  );

  chg_guard_window #(.WINDOW_LEN(WINDOW_LEN)) i_window (
    .clk            (clk),
    .rst_n          (rst_n),
    .hit            (key_hit),
    .sel            (sel),
    .instr_retire   (instr_retire),
    .prot_reg_wr    (prot_reg_wr),
    .prot_prog_exec (prot_prog_exec),
    .mode           (mode),
    .early_close    (early_close),
    .expire         (win_expire)
  );

  chg_guard_viol i_viol (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .prot_reg_wr (prot_reg_wr),
    .blocked     (reg_blocked),
    .violation   (reg_violation)
  );

  for (genvar b = 0; b < KEY_W; b++) begin : g_rd
    assign key_rdata[b] = status_bit(mode, b);
  end

  assign reg_unlock  = (mode == WIN_REG);
  assign prog_unlock = (mode == WIN_PROG);
  assign irq_mask    = (mode != WIN_NONE);
endmodule

// File: rtl/chg_guard_chk.sv
module chg_guard_chk
  import chg_guard_pkg::*;
#(
  parameter int               WINDOW_LEN = 4,
  parameter logic [KEY_W-1:0] SIG_REG    = 8'hD8,
  parameter logic [KEY_W-1:0] SIG_PROG   = 8'h9D
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_we,
  input logic [KEY_W-1:0] key_wdata,
  input logic             instr_retire,
  input logic             prot_reg_wr,
  input logic             prot_prog_exec,
  input logic [KEY_W-1:0] key_rdata,
  input logic             reg_unlock,
  input logic             prog_unlock,
  input logic             irq_mask,
  input logic             reg_violation,
  input logic             key_hit,
  input logic             early_close
);
  localparam int CW = $clog2(WINDOW_LEN + 1) + 1;
  logic [CW-1:0] used_q;
  logic          bad_key;

  assign bad_key = key_we && (key_wdata != SIG_REG) && (key_wdata != SIG_PROG);

  always_ff @(posedge clk) begin
    if (!rst_n)                                            used_q <= '0;
    else if (key_hit)                                      used_q <= '0;
    else if ((reg_unlock || prog_unlock) && instr_retire)  used_q <= used_q + CW'(1);
  end

  AST_REG_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    key_we && key_wdata == SIG_REG |=> reg_unlock && !prog_unlock); // R2
  AST_PROG_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    key_we && key_wdata == SIG_PROG |=> prog_unlock && !reg_unlock); // R3
  AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_unlock || prog_unlock) |-> used_q < CW'(WINDOW_LEN)); // R4
  AST_MASK_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_unlock || prog_unlock) |-> irq_mask); // R5
  AST_SINGLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_unlock && prog_unlock)); // R8
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key && !instr_retire && !prot_reg_wr && !prot_prog_exec |=> $stable(key_rdata)); // R7
  AST_EARLY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    early_close && !key_hit |=> !irq_mask); // R9
  AST_VIOL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    prot_reg_wr && !reg_unlock |=> reg_violation); // R10
  AST_NO_VIOL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    prot_reg_wr && reg_unlock |=> !reg_violation); // R10
endmodule

bind chg_guard chg_guard_chk #(
  .WINDOW_LEN (WINDOW_LEN),
  .SIG_REG    (SIG_REG),
  .SIG_PROG   (SIG_PROG)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .key_we         (key_we),
  .key_wdata      (key_wdata),
  .instr_retire   (instr_retire),
  .prot_reg_wr    (prot_reg_wr),
  .prot_prog_exec (prot_prog_exec),
  .key_rdata      (key_rdata),
  .reg_unlock     (reg_unlock),
  .prog_unlock    (prog_unlock),
  .irq_mask       (irq_mask),
  .reg_violation  (reg_violation),
  .key_hit        (key_hit),
  .early_close    (early_close)
);

// File: tb/test_chg_guard.sv
module test_chg_guard;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_we = 1'b0;
  logic [7:0] key_wdata = 8'h00;
  logic       instr_retire = 1'b0;
  logic       prot_reg_wr = 1'b0;
  logic       prot_prog_exec = 1'b0;
  logic [7:0] key_rdata;
  logic       reg_unlock, prog_unlock, irq_mask, reg_violation;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic       ru;
    logic       pu;
    logic       im;
    logic       vi;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  // Bench reference model: 0 closed, 1 register window, 2 program window
  int m_mode = 0;
  int m_used = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_guard i_chg_guard (
    .clk            (clk),
    .rst_n          (rst_n),
    .key_we         (key_we),
    .key_wdata      (key_wdata),
    .instr_retire   (instr_retire),
    .prot_reg_wr    (prot_reg_wr),
    .prot_prog_exec (prot_prog_exec),
    .key_rdata      (key_rdata),
    .reg_unlock     (reg_unlock),
    .prog_unlock    (prog_unlock),
    .irq_mask       (irq_mask),
    .reg_violation  (reg_violation)
  );

  task automatic step(input bit kw, input logic [7:0] kd, input bit ret,
                      input bit pr, input bit pp, input string tag);
    exp_t e;
    bit   vi;
    @(negedge clk);
    key_we = kw; key_wdata = kd; instr_retire = ret;
    prot_reg_wr = pr; prot_prog_exec = pp;
    vi = pr && (m_mode != 1);
    if (kw && kd == 8'hD8) begin
      m_mode = 1; m_used = 0;
    end else if (kw && kd == 8'h9D) begin
      m_mode = 2; m_used = 0;
    end else if (m_mode != 0) begin
      if ((pr && m_mode == 1) || (pp && m_mode == 2)) m_mode = 0;
      else if (ret) begin
        m_used++;
        if (m_used == 4) m_mode = 0;
      end
    end
    e.rd  = (m_mode == 1) ? 8'h01 : (m_mode == 2) ? 8'h02 : 8'h00;
    e.ru  = (m_mode == 1);
    e.pu  = (m_mode == 2);
    e.im  = (m_mode != 0);
    e.vi  = vi;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compare one scoreboard item per edge, just after the edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (key_rdata !== e.rd || reg_unlock !== e.ru || prog_unlock !== e.pu ||
          irq_mask !== e.im || reg_violation !== e.vi) begin
        errors++;
        $display("FAIL %s: actual rd=%h ru=%b pu=%b im=%b vi=%b expected rd=%h ru=%b pu=%b im=%b vi=%b",
                 e.tag, key_rdata, reg_unlock, prog_unlock, irq_mask, reg_violation,
                 e.rd, e.ru, e.pu, e.im, e.vi);
      end
    end
  end

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (key_rdata !== 8'h00 || reg_unlock || prog_unlock || irq_mask || reg_violation) begin
      errors++;
      $display("FAIL R1: actual rd=%h ru=%b pu=%b im=%b vi=%b expected all zero",
               key_rdata, reg_unlock, prog_unlock, irq_mask, reg_violation);
    end
    idle(2, "R1");

    // R2 / R4 / R5: register window with four retires, some gaps
    step(1, 8'hD8, 0, 0, 0, "R2");
    step(0, 8'h00, 1, 0, 0, "R4");
    idle(1, "R5");
    step(0, 8'h00, 1, 0, 0, "R4");
    step(0, 8'h00, 1, 0, 0, "R4");
    step(0, 8'h00, 1, 0, 0, "R4 close");
    idle(1, "R5");

    // R3 / R4: program window
    step(1, 8'h9D, 0, 0, 0, "R3");
    for (int i = 0; i < 4; i++) step(0, 8'h00, 1, 0, 0, "R4");

    // R6 / R7: junk writes while closed and while open (retire still counts)
    step(1, 8'hFF, 0, 0, 0, "R6");
    step(1, 8'h00, 0, 0, 0, "R7");
    step(1, 8'hD8, 0, 0, 0, "R2");
    step(1, 8'h9C, 1, 0, 0, "R7");
    step(1, 8'hD9, 0, 0, 0, "R7");
    step(0, 8'h00, 1, 0, 0, "R7");
    step(0, 8'h00, 1, 0, 0, "R7");
    step(0, 8'h00, 1, 0, 0, "R7 close");

    // R8: switch mode with a retire in the same cycle; count restarts
    step(1, 8'hD8, 0, 0, 0, "R2");
    step(0, 8'h00, 1, 0, 0, "R8");
    step(0, 8'h00, 1, 0, 0, "R8");
    step(0, 8'h00, 1, 0, 0, "R8");
    step(1, 8'h9D, 1, 0, 0, "R8 switch");
    step(0, 8'h00, 1, 0, 0, "R8");
    step(0, 8'h00, 1, 0, 0, "R8");
    step(0, 8'h00, 1, 0, 0, "R8");
    step(0, 8'h00, 1, 0, 0, "R8 close");

    // R9: wrong-kind strobe keeps window, right kind closes it
    step(1, 8'hD8, 0, 0, 0, "R2");
    step(0, 8'h00, 0, 0, 1, "R9 keep");
    step(0, 8'h00, 0, 1, 0, "R9 close");
    step(1, 8'h9D, 0, 0, 0, "R3");
    step(0, 8'h00, 0, 1, 0, "R10 under prog");
    step(0, 8'h00, 0, 0, 1, "R9 close");

    // R10: blocked write while closed, then a pulse ending after one cycle
    step(0, 8'h00, 0, 1, 0, "R10");
    idle(2, "R10");
    step(0, 8'h00, 0, 1, 0, "R10");
    step(0, 8'h00, 0, 1, 0, "R10");
    idle(2, "R10");

    @(posedge clk);
    #2;
    done = 1'b1;
    report();
  end
endmodule